// File: doc/BRIEF.md
# Byte-Stream Packet Router with Check-Byte Verification

This block takes one byte-wide packet stream and steers each packet into one of three output buffers. Every packet is a destination byte, then a length byte, then 0 to 63 payload bytes, then one check byte. A controller tracks where it is in the packet. When the destination byte arrives, the destination is compared with the fixed address of every output port. The length byte, the payload and the check byte are then written in order into the buffer of the matching port. The destination byte is not stored, because the port it lands in already implies it.

The check byte must equal the XOR of the destination, the length and all payload bytes. A mismatch, or a length above 63, raises a one-cycle error pulse. When the chosen buffer runs full in the middle of a packet, a stall output holds the sender until a reader frees a slot. Each output port presents its oldest byte together with a valid flag, and a reader removes bytes with a per-port read enable.

Top module: `pkt_router`

## Requirements
- R1: During and directly after a synchronous active-low reset, every outValid bit is 0, every outData lane is 0, and inStall and chkErr are 0.
- R2: A byte is taken on a rising edge only when inValid is 1 and inStall is 0. A cycle with inValid low takes nothing.
- R3: Port i has address 8'h00+i (ports 0, 1, 2). A packet whose destination equals a port address appears on that port, in order, as the length byte, the payload bytes and the check byte. The destination byte is not stored.
- R4: A packet whose destination matches no port address writes nothing into any buffer.
- R5: The check byte is the XOR of the destination, length and payload bytes. On a mismatch, chkErr is 1 for exactly one cycle, in the cycle after the check byte is taken. The packet is still forwarded unchanged.
- R6: A length byte above 63 is malformed. chkErr pulses in the cycle after it is taken, nothing of the packet is written, and the next byte taken is treated as a new destination byte.
- R7: A length of 0 stores only the length byte and the check byte. A length of 63 stores 65 bytes.
- R8: Each port buffer holds 16 bytes. While the buffer selected by the current packet holds 16 bytes, inStall is 1 and no byte is taken. No byte is lost or duplicated across a stall.
- R9: When outValid[i] is 1, outData lane i shows the oldest stored byte, and a rising edge with rdEn[i] high removes it. When the buffer is empty, lane i reads 0 and rdEn[i] has no effect.
- R10: A read and a write on the same port in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous reset, active low |
| inData | input | 8 | Incoming packet byte |
| inValid | input | 1 | inData holds a byte to send |
| inStall | output | 1 | Sender must hold inData and inValid |
| chkErr | output | 1 | One-cycle pulse on a check mismatch or a malformed length |
| rdEn | input | 3 | Per-port read enable |
| outData | output | 24 | Head byte of each port, port i in bits 8i+7:8i |
| outValid | output | 3 | Port i buffer is not empty |

## Verification
The hardest state to reach from the ports is a buffer that fills in the middle of a packet while the sender keeps offering the next byte. This is the only case in which stall and acceptance interact, and so the only case in which a byte could be dropped or taken twice. The stimulus sends a packet longer than the buffer while every read is withheld. It then confirms that the stall is up, and only after that drains the port while the rest of the packet is still arriving. The whole byte stream is compared against the expected sequence. A 63-byte packet streamed with concurrent reads covers the same path with reads and writes in the same cycle.

// File: rtl/pkt_router_pkg.sv
package pkt_router_pkg;

  typedef enum logic [1:0] {
    ST_DEST,
    ST_LEN,
    ST_DATA,
    ST_CHK
  } rtr_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeDest;
    logic takeLen;
    logic takeData;
    logic wrByte;
  } rtr_strobe_t;

  // conditions reported by datapath to control
  typedef struct packed {
    logic selFull;
    logic lenBad;
    logic lenZero;
    logic lastData;
    logic chkBad;
  } rtr_status_t;

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
  parameter int DataW = 8,
  parameter int Depth = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [DataW-1:0] wrData,
  input  logic             rdEn,
  output logic [DataW-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PtrW = (Depth > 1) ? $clog2(Depth) : 1;
  localparam int CntW = $clog2(Depth + 1);

  logic [DataW-1:0] mem [Depth];
  logic [PtrW-1:0]  wrPtr, rdPtr;
  logic [CntW-1:0]  cnt;
  logic             doWr, doRd;

  assign full  = (cnt == CntW'(Depth));
  assign empty = (cnt == '0);
  assign doWr  = wrEn && !full;
  assign doRd  = rdEn && !empty;
  assign rdData = empty ? '0 : mem[rdPtr];

  function automatic logic [PtrW-1:0] bump(input logic [PtrW-1:0] p);
    return (p == PtrW'(Depth - 1)) ? '0 : p + PtrW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doWr) wrPtr <= bump(wrPtr);
      if (doRd) rdPtr <= bump(rdPtr);
      if (doWr && !doRd)      cnt <= cnt + CntW'(1);
      else if (doRd && !doWr) cnt <= cnt - CntW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

endmodule

// File: rtl/pkt_router_dp.sv
module pkt_router_dp
  import pkt_router_pkg::*;
#(
  parameter int NumPorts  = 3,
  parameter int DataW     = 8,
  parameter int FifoDepth = 16,
  parameter int MaxLen    = 63,
  parameter int PortBase  = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DataW-1:0]          inData,
  input  rtr_strobe_t               strb,
  output rtr_status_t               stat,
  input  logic [NumPorts-1:0]       rdEn,
  output logic [NumPorts*DataW-1:0] outData,
  output logic [NumPorts-1:0]       outValid,
  output logic [NumPorts-1:0]       fifoFull
);
  localparam int LenW = $clog2(MaxLen + 1);
  localparam int SelW = (NumPorts > 1) ? $clog2(NumPorts) : 1;

  logic [SelW-1:0]  selQ, destSel;
  logic             hitQ, destHit;
  logic [DataW-1:0] accQ;
  logic [LenW-1:0]  remQ;
  logic [NumPorts-1:0] fifoEmpty, fifoWr;

  // compare destination against each port address
  always_comb begin
    destHit = 1'b0;
    destSel = '0;
    for (int i = 0; i < NumPorts; i++) begin
      if (inData == DataW'(PortBase + i)) begin
        destHit = 1'b1;
        destSel = SelW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ <= '0;
      hitQ <= 1'b0;
      accQ <= '0;
      remQ <= '0;
    end else begin
      if (strb.takeDest) begin
        hitQ <= destHit;
        selQ <= destSel;
        accQ <= inData;
      end
      if (strb.takeLen) begin
        accQ <= accQ ^ inData;
        remQ <= inData[LenW-1:0];
      end
      if (strb.takeData) begin
        accQ <= accQ ^ inData;
        remQ <= remQ - LenW'(1);
      end
    end
  end

  always_comb begin
    stat.selFull = 1'b0;
    for (int i = 0; i < NumPorts; i++)
      if (hitQ && selQ == SelW'(i) && fifoFull[i]) stat.selFull = 1'b1;
    stat.lenBad   = (inData > DataW'(MaxLen));
    stat.lenZero  = (inData == '0);
    stat.lastData = (remQ == LenW'(1));
    stat.chkBad   = (inData != accQ);
  end

  for (genvar g = 0; g < NumPorts; g++) begin : g_port
    assign fifoWr[g]   = strb.wrByte && hitQ && (selQ == SelW'(g));
    assign outValid[g] = !fifoEmpty[g];

    pkt_fifo #(
      .DataW(DataW),
      .Depth(FifoDepth)
    ) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .wrEn  (fifoWr[g]),
      .wrData(inData),
      .rdEn  (rdEn[g]),
      .rdData(outData[g*DataW +: DataW]),
      .full  (fifoFull[g]),
      .empty (fifoEmpty[g])
    );
  end

endmodule

// File: rtl/pkt_router_ctrl.sv
module pkt_router_ctrl
  import pkt_router_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  rtr_status_t stat,
  output rtr_strobe_t strb,
  output logic        inStall,
  output logic        chkErr
);
  rtr_state_e state, nxtState;
  logic       accept, errSet;

  // stall depends only on registered state, never on the incoming byte
  assign inStall = (state != ST_DEST) && stat.selFull;
  assign accept  = inValid && !inStall;

  always_comb begin
    strb     = '0;
    nxtState = state;
    errSet   = 1'b0;
    case (state)
      ST_DEST: if (accept) begin
        strb.takeDest = 1'b1;
        nxtState      = ST_LEN;
      end
      ST_LEN: if (accept) begin
        if (stat.lenBad) begin
          errSet   = 1'b1;
          nxtState = ST_DEST;
        end else begin
          strb.takeLen = 1'b1;
          strb.wrByte  = 1'b1;
          nxtState     = stat.lenZero ? ST_CHK : ST_DATA;
        end
      end
      ST_DATA: if (accept) begin
        strb.takeData = 1'b1;
        strb.wrByte   = 1'b1;
        if (stat.lastData) nxtState = ST_CHK;
      end
      ST_CHK: if (accept) begin
        strb.wrByte = 1'b1;
        errSet      = stat.chkBad;
        nxtState    = ST_DEST;
      end
      default: nxtState = ST_DEST;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_DEST;
      chkErr <= 1'b0;
    end else begin
      state  <= nxtState;
      chkErr <= errSet;
    end
  end

endmodule

// File: rtl/pkt_router.sv
module pkt_router
  import pkt_router_pkg::*;
#(
  parameter int NumPorts  = 3,
  parameter int DataW     = 8,
  parameter int FifoDepth = 16,
  parameter int MaxLen    = 63,
  parameter int PortBase  = 0
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [DataW-1:0]          inData,
  input  logic                      inValid,
  output logic                      inStall,
  output logic                      chkErr,
  input  logic [NumPorts-1:0]       rdEn,
  output logic [NumPorts*DataW-1:0] outData,
  output logic [NumPorts-1:0]       outValid
);
  rtr_strobe_t         strb;
  rtr_status_t         stat;
  logic [NumPorts-1:0] fifoFull;

  pkt_router_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .stat   (stat),
    .strb   (strb),
    .inStall(inStall),
    .chkErr (chkErr)
  );

  pkt_router_dp #(
    .NumPorts (NumPorts),
    .DataW    (DataW),
    .FifoDepth(FifoDepth),
    .MaxLen   (MaxLen),
    .PortBase (PortBase)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inData  (inData),
    .strb    (strb),
    .stat    (stat),
    .rdEn    (rdEn),
    .outData (outData),
    .outValid(outValid),
    .fifoFull(fifoFull)
  );

endmodule

// File: rtl/pkt_router_chk.sv
module pkt_router_chk #(
  parameter int NumPorts = 3,
  parameter int DataW    = 8
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      inStall,
  input logic                      chkErr,
  input logic [NumPorts-1:0]       rdEn,
  input logic [NumPorts*DataW-1:0] outData,
  input logic [NumPorts-1:0]       outValid,
  input logic [NumPorts-1:0]       fifoFull
);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (outValid == '0 && !chkErr && !inStall)); // R1

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    chkErr |=> !chkErr); // R5

  AST_STALL_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    inStall |-> (fifoFull != '0)); // R8

  for (genvar g = 0; g < NumPorts; g++) begin : g_port
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      !outValid[g] |-> (outData[g*DataW +: DataW] == '0)); // R9

    AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[g] && !rdEn[g]) |=> outValid[g]); // R9

    AST_HEAD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (outValid[g] && !rdEn[g]) |=> $stable(outData[g*DataW +: DataW])); // R9
  end

endmodule

bind pkt_router pkt_router_chk #(
  .NumPorts(NumPorts),
  .DataW   (DataW)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inStall (inStall),
  .chkErr  (chkErr),
  .rdEn    (rdEn),
  .outData (outData),
  .outValid(outValid),
  .fifoFull(fifoFull)
);

// File: tb/tb_pkt_router.sv
module tb_pkt_router;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  inData;
  logic        inValid;
  logic        inStall;
  logic        chkErr;
  logic [2:0]  rdEn;
  logic [23:0] outData;
  logic [2:0]  outValid;

  int nChecks = 0;
  int nErrs   = 0;
  logic [7:0] expQ [3][$];

  always #4 clk = ~clk;

  pkt_router dut (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid),
    .inStall(inStall), .chkErr(chkErr), .rdEn(rdEn),
    .outData(outData), .outValid(outValid)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErrs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // present a byte and hold it until taken; returns at the negedge after the taking edge
  task automatic sendByte(input logic [7:0] b);
    inData  = b;
    inValid = 1'b1;
    while (inStall) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic sendPkt(input logic [7:0] dest, input int len, input bit corrupt, input int gap);
    logic [7:0] acc;
    logic [7:0] lenB;
    bit hit;
    hit  = (dest < 8'd3);
    lenB = 8'(len);
    acc  = dest ^ lenB;
    sendByte(dest);
    repeat (gap) @(negedge clk);
    if (hit) expQ[dest[1:0]].push_back(lenB);
    sendByte(lenB);
    repeat (gap) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'($urandom);
      acc ^= b;
      if (hit) expQ[dest[1:0]].push_back(b);
      sendByte(b);
      repeat (gap) @(negedge clk);
    end
    if (corrupt) acc ^= 8'h5A;
    if (hit) expQ[dest[1:0]].push_back(acc);
    sendByte(acc);
    check(chkErr == corrupt, "R5 chkErr after check byte", chkErr, corrupt);
  endtask

  task automatic drainPort(input int p, input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] e;
      while (!outValid[p]) @(negedge clk);
      e = (expQ[p].size() > 0) ? expQ[p].pop_front() : 8'hXX;
      check(outData[p*8 +: 8] === e, "R3 output byte order", outData[p*8 +: 8], e);
      rdEn[p] = 1'b1;
      @(negedge clk);
      rdEn[p] = 1'b0;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(outValid == 3'b000 && outData == 24'h0, "R1 outputs in reset", outValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 3'b000, "R1 outValid after reset", outValid, 0);
    check(outData == 24'h0, "R1 outData after reset", outData, 0);
    check(!inStall && !chkErr, "R1 stall/err after reset", {inStall, chkErr}, 0);
  endtask

  task automatic testBasic();
    for (int p = 0; p < 3; p++) begin
      sendPkt(8'(p), 3, 1'b0, 0);
      check(outValid == 3'(1 << p), "R3 only addressed port valid", outValid, 1 << p);
      drainPort(p, 5);
    end
    check(outValid == 3'b000, "R3 all drained", outValid, 0);
  endtask

  task automatic testZeroAndLong();
    sendPkt(8'd1, 0, 1'b0, 0);
    drainPort(1, 2);
    check(!outValid[1], "R7 zero-length stores two bytes", outValid[1], 0);
    // R10: 63-byte packet streamed while port 2 is being read
    fork
      sendPkt(8'd2, 63, 1'b0, 0);
      drainPort(2, 65);
    join
    check(!outValid[2], "R7 long packet stores 65 bytes", outValid[2], 0);
  endtask

  task automatic testNoMatch();
    sendPkt(8'h07, 5, 1'b0, 0);
    sendPkt(8'h03, 0, 1'b0, 0);
    @(negedge clk);
    check(outValid == 3'b000, "R4 unmatched destination writes nothing", outValid, 0);
  endtask

  task automatic testBadCheck();
    sendPkt(8'd0, 4, 1'b1, 0);
    @(negedge clk);
    check(!chkErr, "R5 chkErr lasts one cycle", chkErr, 0);
    drainPort(0, 6);
  endtask

  task automatic testBadLen();
    sendByte(8'd1);
    sendByte(8'd64);
    check(chkErr == 1'b1, "R6 chkErr after malformed length", chkErr, 1);
    @(negedge clk);
    check(outValid == 3'b000, "R6 malformed packet writes nothing", outValid, 0);
    sendPkt(8'd1, 2, 1'b0, 0);
    drainPort(1, 4);
    check(!outValid[1], "R6 next packet intact", outValid[1], 0);
  endtask

  task automatic testStall();
    fork
      sendPkt(8'd1, 18, 1'b0, 0);
      begin
        repeat (30) @(negedge clk);
        check(inStall == 1'b1, "R8 stall while buffer full", inStall, 1);
        check(outValid[1] == 1'b1, "R8 buffer holds data", outValid[1], 1);
        drainPort(1, 20);
      end
    join
    check(!inStall && outValid == 3'b000, "R8 no extra bytes after stall", outValid, 0);
  endtask

  task automatic testEmptyRead();
    rdEn[0] = 1'b1;
    repeat (3) @(negedge clk);
    rdEn[0] = 1'b0;
    check(outValid[0] == 1'b0 && outData[7:0] == 8'h00, "R9 read of empty port", outData[7:0], 0);
    sendPkt(8'd0, 1, 1'b0, 0);
    drainPort(0, 3);
  endtask

  task automatic testGaps();
    sendPkt(8'd2, 5, 1'b0, 2);   // R2 idle cycles between bytes
    drainPort(2, 7);
    check(outValid == 3'b000, "R2 gaps add no bytes", outValid, 0);
  endtask

  task automatic testRandom();
    for (int k = 0; k < 12; k++) begin
      int p, len;
      bit bad;
      p   = $urandom_range(2, 0);
      len = $urandom_range(14, 0);
      bad = ($urandom_range(3, 0) == 0);
      sendPkt(8'(p), len, bad, 0);
      drainPort(p, len + 2);
    end
    check(outValid == 3'b000, "R3 random traffic drained", outValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nErrs++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

  initial begin
    rstN    = 1'b0;
    inData  = 8'h00;
    inValid = 1'b0;
    rdEn    = 3'b000;
    @(negedge clk);
    testReset();
    testBasic();
    testZeroAndLong();
    testNoMatch();
    testBadCheck();
    testBadLen();
    testStall();
    testEmptyRead();
    testGaps();
    testRandom();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErrs, nChecks);
    $finish;
  end

endmodule